// File: doc/BRIEF.md
# Register Rename Map with Free List

This block sits in the rename stage of an out-of-order core. Each cycle it takes one decoded instruction's logical register numbers and translates them into physical register numbers. The physical register file is larger than the logical one. A mapping table holds the current physical register for every logical register. A FIFO holds the physical registers that no instruction owns. Giving every destination a fresh physical register removes write-after-read and write-after-write hazards. Read-after-write links are kept, because later readers see the new mapping.

Both source numbers are looked up combinationally in the current table. When the instruction writes a register, the destination takes the physical register at the head of the free list. The table entry for that logical register is overwritten at the next clock edge. The physical register it replaces is presented on an output. Commit logic holds that value until the instruction retires, then hands it back through the release port. The release port appends it to the tail of the free list. When no free register is left, a writing instruction is stalled and nothing changes.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i, for every logical register. The free list then holds physical registers NUM_LOG through NUM_PHYS-1 in ascending order, with NUM_LOG at the head.
- R2: `src_a_phys` and `src_b_phys` show, in the same cycle, the table entries for `src_a_log` and `src_b_log`.
- R3: When `dst_we` is high and the free list is not empty, `dst_phys` shows the free-list head. Successive allocations take successive free-list entries, so the first three after reset are 8, 9 and 10 at default parameters.
- R4: After an allocation, the table entry of `dst_log` holds the allocated physical register from the next cycle on.
- R5: A source that names the same logical register as the destination of the same instruction gets the mapping from before that instruction's update.
- R6: `dst_prev_phys` shows, in the same cycle, the mapping of `dst_log` before the update.
- R7: When `dst_we` is high and the free list is empty, `stall` is high and neither the table nor the free list changes.
- R8: An instruction with `dst_we` low reads its sources only and does not consume a free-list entry.
- R9: A register presented on `rel_phys` with `rel_valid` high is appended to the free-list tail. Released registers are handed out after every entry already in the list, in release order.
- R10: `stall` depends on the free-list occupancy before the current cycle's release. A release in a cycle when the list is empty does not let a writing instruction in that same cycle proceed. The released register is the next one handed out.
- R11: `stall` is low whenever `dst_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_we | input | 1 | Instruction writes a destination register |
| dst_log | input | LOG_W | Destination logical register |
| src_a_log | input | LOG_W | First source logical register |
| src_b_log | input | LOG_W | Second source logical register |
| rel_valid | input | 1 | A freed physical register is being returned |
| rel_phys | input | PHYS_W | Physical register being returned |
| src_a_phys | output | PHYS_W | First source physical register |
| src_b_phys | output | PHYS_W | Second source physical register |
| dst_phys | output | PHYS_W | Newly allocated destination physical register |
| dst_prev_phys | output | PHYS_W | Mapping of the destination before this update |
| stall | output | 1 | Instruction cannot be renamed this cycle |

## Verification
The bench targets an instruction that reads and writes the same logical register. A design that forwarded the new mapping would return the fresh register as the source and break the data link to the older producer. The bench drains the free list to empty and issues one more writing instruction. A design that popped anyway would hand out a stale register and corrupt the table. It also releases into an empty list in the same cycle as an allocation. A design that let the allocation through would hand out a register in the cycle it returns, which is a hazard for timing. Long random runs compare every output against a reference table and queue. These runs catch out-of-order reuse, lost releases, and instructions without a destination that still consume an entry.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_NUM_LOG  = 8;
  localparam int unsigned DEF_NUM_PHYS = 16;

  // Step a ring pointer with wrap at an arbitrary depth
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_LOG = 8,
  parameter int unsigned PHYS_W  = 4,
  localparam int unsigned LOG_W  = $clog2(NUM_LOG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  rd_a_idx,
  input  logic [LOG_W-1:0]  rd_b_idx,
  input  logic [LOG_W-1:0]  rd_c_idx,
  output logic [PHYS_W-1:0] rd_a_val,
  output logic [PHYS_W-1:0] rd_b_val,
  output logic [PHYS_W-1:0] rd_c_val,
  input  logic              wr_en,
  input  logic [LOG_W-1:0]  wr_idx,
  input  logic [PHYS_W-1:0] wr_val
);
  logic [PHYS_W-1:0] map_q [NUM_LOG];
  logic [PHYS_W-1:0] map_d [NUM_LOG];

  // reads see the state before this cycle's write
  assign rd_a_val = map_q[rd_a_idx];
  assign rd_b_val = map_q[rd_b_idx];
  assign rd_c_val = map_q[rd_c_idx];

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d[wr_idx] = wr_val;
  end

  generate
    for (genvar g = 0; g < NUM_LOG; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     map_q[g] <= PHYS_W'(g);
        else if (wr_en) map_q[g] <= map_d[g];
      end
    end
  endgenerate

  // R4: a written entry carries the written value one cycle later
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned NUM_LOG  = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned PHYS_W  = $clog2(NUM_PHYS),
  localparam int unsigned DEPTH   = NUM_PHYS - NUM_LOG,
  localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  output logic [PHYS_W-1:0] head_val,
  output logic              empty,
  input  logic              push,
  input  logic [PHYS_W-1:0] push_val
);
  logic [PHYS_W-1:0] slot_q [DEPTH];
  logic [PHYS_W-1:0] slot_d [DEPTH];
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop;

  assign empty    = (cnt_q == '0);
  assign head_val = slot_q[head_q];
  assign do_pop   = pop && !empty;

  always_comb begin
    slot_d = slot_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) begin
      slot_d[tail_q] = push_val;
      tail_d = PTR_W'(rn_pkg::ring_next(int'(tail_q), DEPTH));
    end
    if (do_pop) head_d = PTR_W'(rn_pkg::ring_next(int'(head_q), DEPTH));
    if (push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CNT_W'(DEPTH);
    end else begin
      if (do_pop)         head_q <= head_d;
      if (push)           tail_q <= tail_d;
      if (push || do_pop) cnt_q  <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              slot_q[g] <= PHYS_W'(NUM_LOG + g);
        else if (push && tail_q == PTR_W'(g))    slot_q[g] <= slot_d[g];
      end
    end
  endgenerate

  // R9: a release never lands on a full list
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CNT_W'(DEPTH)) || do_pop);
  // R3: a lone pop lowers occupancy by exactly one
  p_pop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R7: an empty list with no release keeps its head
  p_empty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> $stable(head_q) && empty);
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  localparam int unsigned LOG_W   = $clog2(NUM_LOG),
  localparam int unsigned PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_we,
  input  logic [LOG_W-1:0]  dst_log,
  input  logic [LOG_W-1:0]  src_a_log,
  input  logic [LOG_W-1:0]  src_b_log,
  input  logic              rel_valid,
  input  logic [PHYS_W-1:0] rel_phys,
  output logic [PHYS_W-1:0] src_a_phys,
  output logic [PHYS_W-1:0] src_b_phys,
  output logic [PHYS_W-1:0] dst_phys,
  output logic [PHYS_W-1:0] dst_prev_phys,
  output logic              stall
);
  logic fl_empty;
  logic alloc;

  assign stall = dst_we && fl_empty;
  assign alloc = dst_we && !fl_empty;

  rn_map_table #(.NUM_LOG(NUM_LOG), .PHYS_W(PHYS_W)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (src_a_log),
    .rd_b_idx (src_b_log),
    .rd_c_idx (dst_log),
    .rd_a_val (src_a_phys),
    .rd_b_val (src_b_phys),
    .rd_c_val (dst_prev_phys),
    .wr_en    (alloc),
    .wr_idx   (dst_log),
    .wr_val   (dst_phys)
  );

  rn_free_list #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) free_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .head_val (dst_phys),
    .empty    (fl_empty),
    .push     (rel_valid),
    .push_val (rel_phys)
  );

  // R11: stall only for instructions that write
  p_stall_needs_dst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> dst_we);
  // R7: a stalled instruction leaves the destination mapping alone
  p_stall_keeps_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !(dst_we && !stall)) |=> (dst_log != $past(dst_log)) ||
                                       (dst_prev_phys == $past(dst_prev_phys)));
  // R6: the replaced mapping differs from the newly granted register
  p_prev_differs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> dst_prev_phys != dst_phys);
endmodule

// File: tb/reg_rename_tb_top.sv
`timescale 1ns/100ps
module reg_rename_tb_top;
  localparam int NL = 8;
  localparam int NP = 16;
  localparam int D  = NP - NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dst_we = 1'b0, rel_valid = 1'b0;
  logic [2:0] dst_log = '0, src_a_log = '0, src_b_log = '0;
  logic [3:0] rel_phys = '0;
  logic [3:0] src_a_phys, src_b_phys, dst_phys, dst_prev_phys;
  logic stall;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int mdl_map [NL];
  int mdl_fl  [D];
  int mdl_head, mdl_cnt;
  int pool [NP];
  int pool_head, pool_cnt;
  int got_dst, got_a, got_prev, got_stall;

  always #2.5 clk = ~clk;

  reg_rename dut_i (
    .clk(clk), .rst_n(rst_n), .dst_we(dst_we), .dst_log(dst_log),
    .src_a_log(src_a_log), .src_b_log(src_b_log), .rel_valid(rel_valid),
    .rel_phys(rel_phys), .src_a_phys(src_a_phys), .src_b_phys(src_b_phys),
    .dst_phys(dst_phys), .dst_prev_phys(dst_prev_phys), .stall(stall)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mdl_reset();
    for (int i = 0; i < NL; i++) mdl_map[i] = i;
    for (int i = 0; i < D; i++)  mdl_fl[i] = NL + i;
    mdl_head = 0; mdl_cnt = D; pool_head = 0; pool_cnt = 0;
  endtask

  // one instruction: drive at negedge, check before posedge, advance model
  task automatic step(input bit we, input int dl, input int sa, input int sb,
                      input bit rel, input string tag);
    int rp;
    bit exp_stall;
    @(negedge clk);
    rp = 0;
    if (rel && pool_cnt > 0) begin
      rp = pool[pool_head];
      pool_head = (pool_head + 1) % NP;
      pool_cnt--;
    end else rel = 1'b0;
    dst_we = we; dst_log = 3'(dl); src_a_log = 3'(sa); src_b_log = 3'(sb);
    rel_valid = rel; rel_phys = 4'(rp);
    #1;
    exp_stall = we && (mdl_cnt == 0);
    got_dst = int'(dst_phys); got_a = int'(src_a_phys);
    got_prev = int'(dst_prev_phys); got_stall = int'(stall);
    chk(int'(src_a_phys), mdl_map[sa], {tag, " R2 src_a"});
    chk(int'(src_b_phys), mdl_map[sb], {tag, " R2 src_b"});
    chk(int'(stall), int'(exp_stall), {tag, " R7/R11 stall"});
    if (we) chk(int'(dst_prev_phys), mdl_map[dl], {tag, " R6 prev"});
    if (we && !exp_stall) begin
      chk(int'(dst_phys), mdl_fl[mdl_head], {tag, " R3 dst"});
      pool[(pool_head + pool_cnt) % NP] = mdl_map[dl];
      pool_cnt++;
      mdl_map[dl] = mdl_fl[mdl_head];
      mdl_head = (mdl_head + 1) % D;
      mdl_cnt--;
    end
    if (rel) begin
      mdl_fl[(mdl_head + mdl_cnt) % D] = rp;
      mdl_cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mdl_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity map after reset, no stall without destination (R11)
    for (int i = 0; i < NL; i++) begin
      step(1'b0, 0, i, NL - 1 - i, 1'b0, "reset");
      chk(got_a, i, "R1 identity");
      chk(got_stall, 0, "R11 no dst no stall");
    end

    // R3/R5/R6: r3 read and written
    step(1'b1, 3, 3, 0, 1'b0, "d1");
    chk(got_a, 3, "R5 self source old map");
    chk(got_dst, 8, "R3 first alloc");
    chk(got_prev, 3, "R6 prev identity");
    step(1'b1, 5, 0, 0, 1'b0, "d2");
    chk(got_dst, 9, "R3 second alloc");
    step(1'b1, 3, 3, 3, 1'b0, "d3");
    chk(got_a, 8, "R5 self source second");
    chk(got_dst, 10, "R3 third alloc");
    chk(got_prev, 8, "R6 prev renamed");
    step(1'b0, 0, 3, 5, 1'b0, "d4");
    chk(got_a, 10, "R4 table updated");
    // R8: no destination leaves 11 at head
    step(1'b1, 6, 0, 0, 1'b0, "d5");
    chk(got_dst, 11, "R8 no pop without dst");
    // drain
    for (int i = 0; i < 4; i++) step(1'b1, (i == 3) ? 4 : i, 0, 0, 1'b0, "drain");
    // R7: empty stall, map unchanged
    step(1'b1, 7, 7, 0, 1'b0, "empty");
    chk(got_stall, 1, "R7 stall when empty");
    step(1'b0, 0, 7, 0, 1'b0, "after stall");
    chk(got_a, 7, "R7 map unchanged");
    // R9: releases come back in order (pool front: 3 then 5)
    step(1'b0, 0, 0, 0, 1'b1, "rel1");
    step(1'b0, 0, 0, 0, 1'b1, "rel2");
    step(1'b1, 1, 0, 0, 1'b0, "reuse1");
    chk(got_dst, 3, "R9 first released");
    step(1'b1, 2, 0, 0, 1'b0, "reuse2");
    chk(got_dst, 5, "R9 second released");
    // R10: release into empty list with simultaneous allocation
    step(1'b1, 4, 0, 0, 1'b1, "rel empty");
    chk(got_stall, 1, "R10 stall despite release");
    step(1'b1, 4, 0, 0, 1'b0, "after rel");
    chk(got_stall, 0, "R10 next cycle proceeds");
    chk(got_dst, 8, "R10 released reg handed out");

    // random mix against model
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      bit we, rel;
      we  = ($urandom % 4) != 0;
      rel = ($urandom % 2) == 0;
      step(we, $urandom % NL, $urandom % NL, $urandom % NL, rel, "rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule